// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block gathers every fault condition of a two-bridge stepper driver. It turns them into two per-bridge disable signals and one active-low error pin. Its inputs are:

- the thermal warning and thermal shutdown comparators;
- eight over-current detectors, one per driver transistor;
- a "coil at full duty" indication per coil from the PWM regulator;
- a charge-pump-low comparator;
- the motor-enable control bit.

Each fault has its own rule for setting and releasing:

- The thermal warning and charge-pump flags follow their comparators.
- Thermal shutdown is sticky. It releases only on a status read made while the die is cool.
- Over-current bits stay latched per transistor until software clears them.
- Open-coil is detected by a timer. It counts how long a coil has stayed at full PWM duty.

The comparator and detector inputs are asynchronous, so each passes through a two-flop synchronizer before any flag is set from it. The duty indications, the timing tick and the software strobes come from the same clock domain and are used directly. The parameter `OPEN_TICKS` sets the open-coil window in tick periods; the default is 800000 ticks, which is 200 ms at a 4 MHz tick.

Top module: `motor_fault_supervisor`

## Requirements
- R1: While `motor_en` is 0, both bits of `bridge_off` are 1 in the same cycle, whatever the fault state.
- R2: `tw_raw`, `tsd_raw`, `cp_low_raw` and `ovc_raw` pass through two synchronizer flops. A change applied before clock edge k shows in the status outputs after edge k+2 and not earlier. `st_tw` follows the warning comparator in both directions.
- R3: A synchronized shutdown sets `st_tsd`, which drives both bits of `bridge_off` to 1. `st_tsd` clears only on a cycle with `rd_stat` high while both synchronized thermal comparators are low.
- R4: Over-current detector i sets `st_ovc[i]`. Bits 3:0 belong to the X bridge and bits 7:4 to the Y bridge. Any set bit drives both bits of `bridge_off` to 1. A `clr_ovc` cycle clears every bit, except that a detector still asserted keeps or re-sets its own bit in that cycle.
- R5: `duty_full[c]` is for coil c, with 0 = X and 1 = Y. When it has been high on every cycle through `OPEN_TICKS` cycles that carry `tick`, `st_open[c]` sets at the edge of the last such tick and drives `bridge_off[c]` to 1, leaving the other bridge untouched. A cycle with `duty_full[c]` low restarts the count. Cycles without `tick` do not advance it.
- R6: A `clr_open` cycle clears both open-coil bits and restarts both timers.
- R7: `st_cpfail` follows the synchronized charge-pump-low comparator, both set and release.
- R8: `err_n` is 0 exactly when any of `st_tw`, `st_tsd`, `st_ovc`, `st_open` or `st_cpfail` is set. It is combinational from those flags.
- R9: After reset all status flags are 0 and `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing tick for the open-coil timer |
| motor_en | input | 1 | Motor-enable control bit |
| tw_raw | input | 1 | Thermal warning comparator (async) |
| tsd_raw | input | 1 | Thermal shutdown comparator (async) |
| ovc_raw | input | N_FET | Per-transistor over-current detectors (async) |
| cp_low_raw | input | 1 | Charge pump voltage too low (async) |
| duty_full | input | 2 | Coil at full PWM duty, bit 0 X, bit 1 Y |
| rd_stat | input | 1 | Status read strobe |
| clr_ovc | input | 1 | Software clear of over-current bits |
| clr_open | input | 1 | Software clear of open-coil bits |
| st_tw | output | 1 | Thermal warning flag |
| st_tsd | output | 1 | Thermal shutdown flag |
| st_ovc | output | N_FET | Latched over-current bits |
| st_open | output | 2 | Open-coil bits, bit 0 X, bit 1 Y |
| st_cpfail | output | 1 | Charge pump fail flag |
| bridge_off | output | 2 | Bridge disable, bit 0 X, bit 1 Y |
| err_n | output | 1 | Active-low error output |

## Verification
Comparator-driven results are due three clock edges after the input changes: two synchronizer stages and the flag register. The bench drives each input on a falling edge, waits three rising edges, and samples on the next falling edge. One check samples one edge early to confirm the flag has not yet moved. Read and clear strobes, and the tick-driven open-coil timer, act at the very next rising edge, so their results are sampled one falling edge after the pulse or after the last counted tick. The open-coil check also samples one tick before the window ends to confirm the bit is still clear. `bridge_off` and `err_n` are combinational from the flags and `motor_en`, so they are sampled together with the flags.

// File: rtl/motor_fault_supervisor.sv
`timescale 1ns/1ps
module motor_fault_supervisor #(
  parameter int OPEN_TICKS = 800000,
  parameter int N_FET      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             motor_en,
  input  logic             tw_raw,
  input  logic             tsd_raw,
  input  logic [N_FET-1:0] ovc_raw,
  input  logic             cp_low_raw,
  input  logic [1:0]       duty_full,
  input  logic             rd_stat,
  input  logic             clr_ovc,
  input  logic             clr_open,
  output logic             st_tw,
  output logic             st_tsd,
  output logic [N_FET-1:0] st_ovc,
  output logic [1:0]       st_open,
  output logic             st_cpfail,
  output logic [1:0]       bridge_off,
  output logic             err_n
);
  localparam int SW = N_FET + 3;
  localparam int CW = $clog2(OPEN_TICKS + 1);

  logic [SW-1:0]    sync1, sync2;
  logic             tw_s, tsd_s, cp_s;
  logic [N_FET-1:0] ovc_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {cp_low_raw, tsd_raw, tw_raw, ovc_raw};
      sync2 <= sync1;
    end

  assign ovc_s = sync2[N_FET-1:0];
  assign tw_s  = sync2[N_FET];
  assign tsd_s = sync2[N_FET+1];
  assign cp_s  = sync2[N_FET+2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_tw     <= 1'b0;
      st_cpfail <= 1'b0;
      st_tsd    <= 1'b0;
      st_ovc    <= '0;
    end else begin
      st_tw     <= tw_s;
      st_cpfail <= cp_s;
      if (tsd_s)                         st_tsd <= 1'b1;
      else if (rd_stat && !tw_s)         st_tsd <= 1'b0;
      st_ovc <= (clr_ovc ? '0 : st_ovc) | ovc_s;
    end

  AST_TSD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_tsd && (!rd_stat || tw_s || tsd_s) |=> st_tsd); // R3
  AST_OVC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ovc |=> ((st_ovc & $past(st_ovc)) == $past(st_ovc))); // R4
  AST_OVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovc && (ovc_s == '0) |=> (st_ovc == '0)); // R4
  AST_CP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_cpfail) |-> $past(cp_low_raw, 3)); // R2

  for (genvar c = 0; c < 2; c++) begin : g_coil
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt        <= '0;
        st_open[c] <= 1'b0;
      end else if (clr_open) begin
        cnt        <= '0;
        st_open[c] <= 1'b0;
      end else if (!duty_full[c]) begin
        cnt <= '0;
      end else if (tick && !st_open[c]) begin
        if (cnt == CW'(OPEN_TICKS - 1)) st_open[c] <= 1'b1;
        else                            cnt <= cnt + 1'b1;
      end

    AST_OPEN_NEEDS_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_open[c]) |-> $past(duty_full[c]) && $past(tick)); // R5
    AST_OPEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_open |=> !st_open[c]); // R6
  end

  for (genvar c = 0; c < 2; c++) begin : g_gate
    assign bridge_off[c] = !motor_en || st_tsd || (|st_ovc) || st_open[c];
  end

  assign err_n = !(st_tw || st_tsd || (|st_ovc) || (|st_open) || st_cpfail);
endmodule

// File: tb/test_motor_fault_supervisor.sv
`timescale 1ns/1ps
module test_motor_fault_supervisor;
  localparam int OT = 6;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, motor_en = 1'b1;
  logic tw_raw = 1'b0, tsd_raw = 1'b0, cp_low_raw = 1'b0;
  logic [7:0] ovc_raw = '0;
  logic [1:0] duty_full = '0;
  logic rd_stat = 1'b0, clr_ovc = 1'b0, clr_open = 1'b0;
  logic st_tw, st_tsd, st_cpfail, err_n;
  logic [7:0] st_ovc;
  logic [1:0] st_open, bridge_off;
  int total = 0, fails = 0;

  motor_fault_supervisor #(.OPEN_TICKS(OT), .N_FET(8)) i_motor_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .motor_en(motor_en),
    .tw_raw(tw_raw), .tsd_raw(tsd_raw), .ovc_raw(ovc_raw), .cp_low_raw(cp_low_raw),
    .duty_full(duty_full), .rd_stat(rd_stat), .clr_ovc(clr_ovc), .clr_open(clr_open),
    .st_tw(st_tw), .st_tsd(st_tsd), .st_ovc(st_ovc), .st_open(st_open),
    .st_cpfail(st_cpfail), .bridge_off(bridge_off), .err_n(err_n));

  always #4 clk = ~clk;

  // {motor_en, tw, cp_low, exp err_n, exp bridge_off[0], exp bridge_off[1]}
  localparam logic [5:0] VEC [6] = '{
    6'b100_100, 6'b000_111, 6'b110_000, 6'b101_000, 6'b011_011, 6'b100_100};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R9 err_n in reset", err_n, 1);
    chk("R9 flags in reset", {st_tw, st_tsd, st_ovc, st_open, st_cpfail}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 6; v++) begin
      {motor_en, tw_raw, cp_low_raw} = VEC[v][5:3];
      cyc(3);
      chk("R8 err_n vector", err_n, VEC[v][2]);
      chk("R1 bridge_off vector", bridge_off, {VEC[v][0], VEC[v][1]});
      chk("R7 cpfail follows", st_cpfail, VEC[v][3]);
      chk("R2 tw follows", st_tw, VEC[v][4]);
    end

    tw_raw = 1'b1; cyc(2);
    chk("R2 tw not before third edge", st_tw, 0);
    cyc(1);
    chk("R2 tw at third edge", st_tw, 1);

    tsd_raw = 1'b1; cyc(3);
    chk("R3 tsd set", st_tsd, 1);
    chk("R3 tsd disables both", bridge_off, 2'b11);
    tsd_raw = 1'b0; cyc(3);
    rd_stat = 1'b1; cyc(1); rd_stat = 1'b0;
    chk("R3 read while warm keeps tsd", st_tsd, 1);
    tw_raw = 1'b0; cyc(4);
    chk("R3 cool without read keeps tsd", st_tsd, 1);
    rd_stat = 1'b1; cyc(1); rd_stat = 1'b0;
    chk("R3 cool read clears tsd", st_tsd, 0);
    chk("R3 bridges back on", bridge_off, 2'b00);
    chk("R8 err_n released", err_n, 1);

    ovc_raw = 8'h20; cyc(3);
    chk("R4 ovc bit5 set", st_ovc, 8'h20);
    chk("R4 ovc disables both", bridge_off, 2'b11);
    ovc_raw = 8'h00; cyc(3);
    chk("R4 ovc stays latched", st_ovc, 8'h20);
    ovc_raw = 8'h01; cyc(3);
    chk("R4 ovc bit0 added", st_ovc, 8'h21);
    clr_ovc = 1'b1; cyc(1); clr_ovc = 1'b0;
    chk("R4 clear keeps active detector", st_ovc, 8'h01);
    ovc_raw = 8'h00; cyc(3);
    clr_ovc = 1'b1; cyc(1); clr_ovc = 1'b0;
    chk("R4 clear all", st_ovc, 8'h00);
    chk("R8 err_n after ovc clear", err_n, 1);

    tick = 1'b1; duty_full = 2'b01; cyc(OT - 1);
    chk("R5 open not one tick early", st_open, 2'b00);
    cyc(1);
    chk("R5 open x set", st_open, 2'b01);
    chk("R5 only x bridge off", bridge_off, 2'b01);
    chk("R8 err_n on open", err_n, 0);
    duty_full = 2'b00; clr_open = 1'b1; cyc(1); clr_open = 1'b0;
    chk("R6 open cleared", st_open, 2'b00);

    duty_full = 2'b10; cyc(OT - 2);
    duty_full = 2'b00; cyc(1);
    duty_full = 2'b10; cyc(OT - 1);
    chk("R5 gap restarts timer", st_open, 2'b00);
    cyc(1);
    chk("R5 open y set", st_open, 2'b10);
    chk("R5 only y bridge off", bridge_off, 2'b10);

    duty_full = 2'b00; clr_open = 1'b1; cyc(1); clr_open = 1'b0;
    tick = 1'b0; duty_full = 2'b11; cyc(3 * OT);
    chk("R5 no count without tick", st_open, 2'b00);
    clr_open = 1'b1; tick = 1'b1; cyc(OT + 2); clr_open = 1'b0;
    chk("R6 clear holds timers", st_open, 2'b00);
    duty_full = 2'b00; cyc(1);
    chk("R8 err_n idle", err_n, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule